// File: doc/BRIEF.md
# GPIO Pin Group Controller

This block controls one group of 32 general-purpose I/O pins behind a simple register bus: a byte address, a 32-bit write word, a write strobe and a combinational read word. It holds the direction and output latches for all pins. Both latches have alias addresses that set, clear or toggle only the bits written as one, so software can touch one pin without a read-modify-write. Pad inputs pass through a two-stage synchronizer into a readable register.

Every pin also owns a small configuration (mux enable, input enable, pull enable, drive strength) and a 4-bit peripheral function select. Two pins share each function-select byte. A write-only bulk configuration word changes these fields for any subset of one half of the group in a single write. No other pin is disturbed, so no shared byte has to be read and merged first. The block drives the pad control lines directly. A pin's pull direction follows its output latch.

Top module: `pin_group_port`

## Requirements
- R1: After reset every register is zero: all pins are inputs with output, input buffer, pull, drive strength and mux disabled, and every pad control output is zero.
- R2: The direction word is written directly at 0x00. At 0x04, 0x08 and 0x0C the written ones clear, set or toggle the matching direction bits and zero bits leave pins unchanged. All four addresses read back the direction word.
- R3: The output word works the same way at 0x10 (direct write), 0x14 (clear), 0x18 (set) and 0x1C (toggle), and all four read back the output word.
- R4: Address 0x20 reads the pad inputs through two flip-flops: a pad change set up before clock edge k shows in the read after edge k+1 and not before.
- R5: Byte 0x30+i holds the function selects of pin 2i (bits 3:0) and pin 2i+1 (bits 7:4). A written nibble above 13 leaves that pin's select unchanged, while the other nibble of the same byte is still written.
- R6: Byte 0x40+p is pin p's configuration: bit 0 mux enable, bit 1 input enable, bit 2 pull enable, bit 6 drive strength. The other bits read zero.
- R7: The bulk word at 0x28 uses pin mask bits 15:0, mux enable 16, input enable 17, pull enable 18, drive strength 22, function 27:24, mux-update enable 28, config-update enable 30 and half select 31. With half select at 1, mask bit k names pin k+16, otherwise pin k. The word reads as zero.
- R8: A bulk write changes the configuration fields only when bit 30 is set and the function select only when bit 28 is set, and only for the masked pins. All other pins keep their settings.
- R9: A bulk write whose function value is above 13 updates no function select, while its configuration update still applies.
- R10: The pad output enable is the direction bit masked by the pin's mux enable. The pad output value, input enable, drive strength and mux enable mirror the latches. Function select p appears on bits 4p+3:4p of the mux select bus.
- R11: A pin with pull enabled drives the pull-up line when its output bit is 1 and the pull-down line when it is 0. With pull disabled, neither line is driven.
- R12: Reserved addresses (0x24, 0x2C to 0x2F, 0x60 and above) read zero, and writing to them changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | 8 | Byte address |
| busWdata | input | 32 | Write data; byte registers take bits 7:0 |
| busWen | input | 1 | Write strobe, one write per asserted cycle |
| busRdata | output | 32 | Read data for busAddr, combinational |
| padIn | input | 32 | Pad input levels |
| padOe | output | 32 | Pad output enable |
| padOut | output | 32 | Pad output value |
| padIe | output | 32 | Pad input buffer enable |
| padPullUp | output | 32 | Pull-up enable |
| padPullDown | output | 32 | Pull-down enable |
| padDrv | output | 32 | Strong drive enable |
| padMuxEn | output | 32 | Peripheral mux enable |
| padMuxSel | output | 128 | Function select, 4 bits per pin |

## Verification
A corrupted latch bit reaches the pads in the same cycle it is stored. A wrong direction, output or configuration value therefore shows on the pad lines right after the faulty write and on a read of the owning address. A bulk write that hits the wrong half or the wrong pins shows only when that pin's configuration or select byte is read or its pad lines are checked. The bench therefore reads masked and unmasked neighbours after each bulk write. A synchronizer with a missing or extra stage moves the input word by one cycle, so the input is sampled at each of the three cycles around the change.

// File: rtl/pinport_pkg.sv
package pinport_pkg;

  localparam int PIN_COUNT  = 32;
  localparam int SEL_W      = 4;
  localparam int MAX_FUNC   = 13;
  localparam int PIN_IDX_W  = $clog2(PIN_COUNT);

  // bulk configuration word bit positions
  localparam int BK_MUXEN   = 16;
  localparam int BK_INEN    = 17;
  localparam int BK_PULL    = 18;
  localparam int BK_DRV     = 22;
  localparam int BK_FUNC_LO = 24;
  localparam int BK_WRMUX   = 28;
  localparam int BK_WRCFG   = 30;
  localparam int BK_HIGH    = 31;

  typedef enum logic [2:0] {
    RD_ZERO, RD_DIR, RD_OUT, RD_IN, RD_MUX, RD_PCFG
  } rd_sel_e;

  typedef struct packed {
    logic drv;
    logic pull;
    logic inen;
    logic muxEn;
  } pcfg_t;

  typedef struct packed {
    logic dirLoad;
    logic dirSet;
    logic dirClr;
    logic dirTgl;
    logic outLoad;
    logic outSet;
    logic outClr;
    logic outTgl;
    logic cfgBulk;
    logic muxByte;
    logic pinByte;
    logic [PIN_IDX_W-1:0] idx;
    rd_sel_e rdSel;
  } strobe_t;

endpackage

// File: rtl/pinport_ctrl.sv
module pinport_ctrl
  import pinport_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWen,
  output strobe_t           stb
);

  localparam logic [ADDR_W-1:0] WORD_END = ADDR_W'(8'h2C);

  always_comb begin
    stb = '0;
    stb.rdSel = RD_ZERO;
    if (busAddr < WORD_END) begin
      unique case (busAddr[5:2])
        4'd0:  begin stb.rdSel = RD_DIR; stb.dirLoad = busWen; end
        4'd1:  begin stb.rdSel = RD_DIR; stb.dirClr  = busWen; end
        4'd2:  begin stb.rdSel = RD_DIR; stb.dirSet  = busWen; end
        4'd3:  begin stb.rdSel = RD_DIR; stb.dirTgl  = busWen; end
        4'd4:  begin stb.rdSel = RD_OUT; stb.outLoad = busWen; end
        4'd5:  begin stb.rdSel = RD_OUT; stb.outClr  = busWen; end
        4'd6:  begin stb.rdSel = RD_OUT; stb.outSet  = busWen; end
        4'd7:  begin stb.rdSel = RD_OUT; stb.outTgl  = busWen; end
        4'd8:  stb.rdSel = RD_IN;
        4'd10: stb.cfgBulk = busWen;   // write-only, reads zero (R7)
        default: stb.rdSel = RD_ZERO;  // reserved word (R12)
      endcase
    end else if (busAddr[ADDR_W-1:4] == (ADDR_W-4)'(3)) begin
      stb.rdSel   = RD_MUX;
      stb.muxByte = busWen;
      stb.idx     = PIN_IDX_W'(busAddr[3:0]);
    end else if (busAddr[ADDR_W-1:5] == (ADDR_W-5)'(2)) begin
      stb.rdSel   = RD_PCFG;
      stb.pinByte = busWen;
      stb.idx     = busAddr[PIN_IDX_W-1:0];
    end
  end

endmodule

// File: rtl/pinport_datapath.sv
module pinport_datapath
  import pinport_pkg::*;
#(
  parameter int NPIN        = PIN_COUNT,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               stb,
  input  logic [31:0]           busWdata,
  input  logic [NPIN-1:0]       padIn,
  output logic [31:0]           busRdata,
  output logic [NPIN-1:0]       padOe,
  output logic [NPIN-1:0]       padOut,
  output logic [NPIN-1:0]       padIe,
  output logic [NPIN-1:0]       padPullUp,
  output logic [NPIN-1:0]       padPullDown,
  output logic [NPIN-1:0]       padDrv,
  output logic [NPIN-1:0]       padMuxEn,
  output logic [NPIN*SEL_W-1:0] padMuxSel
);

  localparam int HALF = NPIN / 2;

  logic [NPIN-1:0]  dirQ;
  logic [NPIN-1:0]  outQ;
  logic [NPIN-1:0]  syncQ [SYNC_STAGES];
  pcfg_t            cfgQ  [NPIN];
  logic [SEL_W-1:0] muxQ  [NPIN];
  logic [NPIN-1:0]  bulkHit;

  // direction latch with set / clear / toggle aliases
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            dirQ <= '0;
    else if (stb.dirLoad) dirQ <= busWdata[NPIN-1:0];
    else if (stb.dirSet)  dirQ <= dirQ | busWdata[NPIN-1:0];
    else if (stb.dirClr)  dirQ <= dirQ & ~busWdata[NPIN-1:0];
    else if (stb.dirTgl)  dirQ <= dirQ ^ busWdata[NPIN-1:0];
  end

  // output latch with set / clear / toggle aliases
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            outQ <= '0;
    else if (stb.outLoad) outQ <= busWdata[NPIN-1:0];
    else if (stb.outSet)  outQ <= outQ | busWdata[NPIN-1:0];
    else if (stb.outClr)  outQ <= outQ & ~busWdata[NPIN-1:0];
    else if (stb.outTgl)  outQ <= outQ ^ busWdata[NPIN-1:0];
  end

  // input synchronizer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncQ[s] <= '0;
    end else begin
      syncQ[0] <= padIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncQ[s] <= syncQ[s-1];
    end
  end

  // per-pin configuration and function select
  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    localparam int   MASK_BIT = p % HALF;
    localparam logic UPPER    = (p >= HALF) ? 1'b1 : 1'b0;
    localparam int   NIB_LO   = (p % 2) * SEL_W;

    logic [SEL_W-1:0] byteNib;
    logic [SEL_W-1:0] bulkFunc;
    assign byteNib  = busWdata[NIB_LO +: SEL_W];
    assign bulkFunc = busWdata[BK_FUNC_LO +: SEL_W];
    assign bulkHit[p] = stb.cfgBulk && busWdata[MASK_BIT] && (busWdata[BK_HIGH] == UPPER);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        cfgQ[p] <= '0;
      else if (stb.pinByte && stb.idx == PIN_IDX_W'(p))
        cfgQ[p] <= '{drv: busWdata[6], pull: busWdata[2], inen: busWdata[1], muxEn: busWdata[0]};
      else if (bulkHit[p] && busWdata[BK_WRCFG])
        cfgQ[p] <= '{drv: busWdata[BK_DRV], pull: busWdata[BK_PULL],
                     inen: busWdata[BK_INEN], muxEn: busWdata[BK_MUXEN]};
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        muxQ[p] <= '0;
      else if (stb.muxByte && stb.idx == PIN_IDX_W'(p / 2)) begin
        if (byteNib <= SEL_W'(MAX_FUNC)) muxQ[p] <= byteNib;
      end else if (bulkHit[p] && busWdata[BK_WRMUX] && bulkFunc <= SEL_W'(MAX_FUNC))
        muxQ[p] <= bulkFunc;
    end

    assign padOe[p]       = dirQ[p] & ~cfgQ[p].muxEn;
    assign padOut[p]      = outQ[p];
    assign padIe[p]       = cfgQ[p].inen;
    assign padPullUp[p]   = cfgQ[p].pull & outQ[p];
    assign padPullDown[p] = cfgQ[p].pull & ~outQ[p];
    assign padDrv[p]      = cfgQ[p].drv;
    assign padMuxEn[p]    = cfgQ[p].muxEn;
    assign padMuxSel[p*SEL_W +: SEL_W] = muxQ[p];

    assert_mux_legal_R5: assert property (@(posedge clk) disable iff (!rstN)
      muxQ[p] <= SEL_W'(MAX_FUNC));

    assert_bulk_unmasked_R8: assert property (@(posedge clk) disable iff (!rstN)
      (stb.cfgBulk && !bulkHit[p]) |=> ($stable(cfgQ[p]) && $stable(muxQ[p])));
  end

  // read multiplexer
  pcfg_t            rdCfg;
  logic [PIN_IDX_W-1:0] loIdx, hiIdx;
  assign rdCfg = cfgQ[stb.idx];
  assign loIdx = {stb.idx[PIN_IDX_W-2:0], 1'b0};
  assign hiIdx = {stb.idx[PIN_IDX_W-2:0], 1'b1};

  always_comb begin
    busRdata = '0;
    unique case (stb.rdSel)
      RD_DIR:  busRdata = 32'(dirQ);
      RD_OUT:  busRdata = 32'(outQ);
      RD_IN:   busRdata = 32'(syncQ[SYNC_STAGES-1]);
      RD_MUX:  busRdata = {24'b0, muxQ[hiIdx], muxQ[loIdx]};
      RD_PCFG: busRdata = {25'b0, rdCfg.drv, 3'b0, rdCfg.pull, rdCfg.inen, rdCfg.muxEn};
      default: busRdata = '0;
    endcase
  end

  // assertions on latch behaviour
  assert_dir_set_R2: assert property (@(posedge clk) disable iff (!rstN)
    stb.dirSet |=> dirQ == ($past(dirQ) | $past(busWdata[NPIN-1:0])));

  assert_out_clr_R3: assert property (@(posedge clk) disable iff (!rstN)
    stb.outClr |=> outQ == ($past(outQ) & ~$past(busWdata[NPIN-1:0])));

  if (SYNC_STAGES == 2) begin : g_sync_chk
    logic [1:0] sinceRst;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)               sinceRst <= '0;
      else if (sinceRst != 2'd2) sinceRst <= sinceRst + 2'd1;
    end
    assert_in_delay_R4: assert property (@(posedge clk) disable iff (!rstN)
      (sinceRst == 2'd2) |-> syncQ[1] == $past(padIn, 2));
  end

endmodule

// File: rtl/pin_group_port.sv
module pin_group_port
  import pinport_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [ADDR_W-1:0]          busAddr,
  input  logic [31:0]                busWdata,
  input  logic                       busWen,
  output logic [31:0]                busRdata,
  input  logic [PIN_COUNT-1:0]       padIn,
  output logic [PIN_COUNT-1:0]       padOe,
  output logic [PIN_COUNT-1:0]       padOut,
  output logic [PIN_COUNT-1:0]       padIe,
  output logic [PIN_COUNT-1:0]       padPullUp,
  output logic [PIN_COUNT-1:0]       padPullDown,
  output logic [PIN_COUNT-1:0]       padDrv,
  output logic [PIN_COUNT-1:0]       padMuxEn,
  output logic [PIN_COUNT*SEL_W-1:0] padMuxSel
);

  strobe_t stb;

  pinport_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busAddr (busAddr),
    .busWen  (busWen),
    .stb     (stb)
  );

  pinport_datapath #(.NPIN(PIN_COUNT), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .busWdata    (busWdata),
    .padIn       (padIn),
    .busRdata    (busRdata),
    .padOe       (padOe),
    .padOut      (padOut),
    .padIe       (padIe),
    .padPullUp   (padPullUp),
    .padPullDown (padPullDown),
    .padDrv      (padDrv),
    .padMuxEn    (padMuxEn),
    .padMuxSel   (padMuxSel)
  );

endmodule

// File: tb/sim_pin_group_port.sv
`timescale 1ns/1ps
module sim_pin_group_port;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [7:0]   busAddr = '0;
  logic [31:0]  busWdata = '0;
  logic         busWen = 1'b0;
  logic [31:0]  busRdata;
  logic [31:0]  padIn = '0;
  logic [31:0]  padOe, padOut, padIe, padPullUp, padPullDown, padDrv, padMuxEn;
  logic [127:0] padMuxSel;

  int applied = 0;
  int misses  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  pin_group_port u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWdata(busWdata), .busWen(busWen),
    .busRdata(busRdata), .padIn(padIn), .padOe(padOe), .padOut(padOut), .padIe(padIe),
    .padPullUp(padPullUp), .padPullDown(padPullDown), .padDrv(padDrv),
    .padMuxEn(padMuxEn), .padMuxSel(padMuxSel)
  );

  typedef struct packed {
    logic [7:0]  wa;
    logic [31:0] wd;
    logic [7:0]  ra;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NVEC = 14;
  localparam vec_t VECS [NVEC] = '{
    '{8'h00, 32'h0000_00F0, 8'h00, 32'h0000_00F0, 8'd2},  // R2 direct write
    '{8'h08, 32'h0000_0F00, 8'h00, 32'h0000_0FF0, 8'd2},  // R2 set
    '{8'h04, 32'h0000_0030, 8'h0C, 32'h0000_0FC0, 8'd2},  // R2 clear, alias read
    '{8'h0C, 32'h8000_0041, 8'h00, 32'h8000_0F81, 8'd2},  // R2 toggle
    '{8'h10, 32'h1234_5678, 8'h10, 32'h1234_5678, 8'd3},  // R3 direct write
    '{8'h18, 32'h0000_000F, 8'h10, 32'h1234_567F, 8'd3},  // R3 set
    '{8'h14, 32'h1200_0000, 8'h10, 32'h0034_567F, 8'd3},  // R3 clear
    '{8'h1C, 32'hFF00_0000, 8'h1C, 32'hFF34_567F, 8'd3},  // R3 toggle, alias read
    '{8'h31, 32'h0000_005C, 8'h31, 32'h0000_005C, 8'd5},  // R5 pins 2 and 3
    '{8'h31, 32'h0000_00E7, 8'h31, 32'h0000_0057, 8'd5},  // R5 illegal high nibble kept
    '{8'h45, 32'h0000_00FF, 8'h45, 32'h0000_0047, 8'd6},  // R6 unused bits read zero
    '{8'h45, 32'h0000_0002, 8'h45, 32'h0000_0002, 8'd6},  // R6 input enable only
    '{8'h24, 32'hFFFF_FFFF, 8'h24, 32'h0000_0000, 8'd12}, // R12 reserved word
    '{8'h60, 32'hFFFF_FFFF, 8'h00, 32'h8000_0F81, 8'd12}  // R12 no side effect
  };

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWen = 1'b1;
    @(negedge clk);
    busWen = 1'b0;
  endtask

  task automatic chkVal(input string tag, input logic [31:0] act, input logic [31:0] exp);
    applied++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic rdChk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    busAddr = a;
    #1;
    chkVal($sformatf("%s addr %02h", tag, a), busRdata, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      misses++;
      $display("FAIL watchdog actual running expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", applied, misses);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rdChk("R1", 8'h00, 32'h0);
    rdChk("R1", 8'h10, 32'h0);
    rdChk("R1", 8'h20, 32'h0);
    rdChk("R1", 8'h30, 32'h0);
    rdChk("R1", 8'h5F, 32'h0);
    chkVal("R1 padOe", padOe, 32'h0);
    chkVal("R1 padIe", padIe, 32'h0);
    chkVal("R1 pulls", padPullUp | padPullDown, 32'h0);
    chkVal("R1 padMuxEn", padMuxEn, 32'h0);
    chkVal("R1 padMuxSel", 32'(|padMuxSel), 32'h0);

    // register table
    for (int i = 0; i < NVEC; i++) begin
      wr(VECS[i].wa, VECS[i].wd);
      busAddr = VECS[i].ra;
      #1;
      applied++;
      if (busRdata !== VECS[i].exp) begin
        misses++;
        $display("FAIL R%0d vector %0d actual %08h expected %08h",
                 VECS[i].req, i, busRdata, VECS[i].exp);
      end
    end

    // R4 two-stage input path
    @(negedge clk);
    padIn = 32'hA5A5_0001;
    rdChk("R4 before edge", 8'h20, 32'h0);
    @(negedge clk);
    rdChk("R4 one edge", 8'h20, 32'h0);
    @(negedge clk);
    rdChk("R4 two edges", 8'h20, 32'hA5A5_0001);

    // R7 upper half, pins 16 and 19, config and mux update
    wr(8'h28, 32'hD446_0009);
    rdChk("R7 reads zero", 8'h28, 32'h0);
    rdChk("R7 pin16 cfg", 8'h50, 32'h46);
    rdChk("R7 pin19 cfg", 8'h53, 32'h46);
    rdChk("R7 pin0 untouched", 8'h40, 32'h0);
    rdChk("R8 pin17 unmasked", 8'h51, 32'h0);
    rdChk("R8 mux pins16-17", 8'h38, 32'h04);
    rdChk("R8 mux pins18-19", 8'h39, 32'h40);

    // R8 mux update only, pin 2
    wr(8'h28, 32'h1904_0004);
    rdChk("R8 mux only", 8'h31, 32'h59);
    rdChk("R8 cfg kept", 8'h42, 32'h0);

    // R9 illegal function, config still applied, pin 2
    wr(8'h28, 32'h5E01_0004);
    rdChk("R9 mux kept", 8'h31, 32'h59);
    rdChk("R9 cfg applied", 8'h42, 32'h01);

    // R10 pad outputs, pin 7 mux enabled
    wr(8'h47, 32'h0000_0001);
    chkVal("R10 padOe", padOe, 32'h8000_0F01);
    chkVal("R10 padMuxEn", padMuxEn, 32'h0000_0084);
    chkVal("R10 padOut", padOut, 32'hFF34_567F);
    chkVal("R10 padIe", padIe, 32'h0009_0020);
    chkVal("R10 padDrv", padDrv, 32'h0009_0000);
    chkVal("R10 sel pin2", 32'(padMuxSel[11:8]), 32'h9);
    chkVal("R10 sel pin3", 32'(padMuxSel[15:12]), 32'h5);
    chkVal("R10 sel pin19", 32'(padMuxSel[79:76]), 32'h4);

    // R11 pull direction from output latch
    chkVal("R11 pull-down", padPullDown, 32'h0009_0000);
    chkVal("R11 pull-up", padPullUp, 32'h0);
    wr(8'h18, 32'h0008_0000);
    chkVal("R11 pull-up after set", padPullUp, 32'h0008_0000);
    chkVal("R11 pull-down after set", padPullDown, 32'h0001_0000);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", applied, misses);
    $finish;
  end

endmodule